// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer for 9-bit words. Its write side and its read side each have their own clock. The two clocks may be the same net or may have no relation to each other. A word enters on a write-clock rising edge only when both write enables are high. A word leaves on a read-clock rising edge only when both read enables are high. The read data register updates on the edge that accepts the read.

Four flags report the fill level:
- empty and almost-empty are produced in the read domain;
- full and almost-full are produced in the write domain.

The two near-end thresholds are programmable. They are loaded one after the other through a strobe and a data word on the write side, and both return to 7 on reset. The pointers cross between the clock domains as Gray code through two-flop synchronizers. A drive-enable output sits beside the read data. It follows the output-enable input, so an external pad or a bus mux can float the data lines.

The reset `rst` is synchronous and active high. Each clock domain samples it on its own clock, so it must be held for several edges of the slower clock.

Top module: `dual_clk_fifo_pf`

## Requirements
- R1: A word is stored only on a write-clock edge where wr_en_a and wr_en_b are both 1 and full is 0. A single asserted write enable stores nothing.
- R2: A read is accepted only on a read-clock edge where rd_en_a and rd_en_b are both 1 and empty is 0. On that edge rd_data takes the oldest stored word, so words come out in write order.
- R3: full is 1 exactly when DEPTH words are held (default DEPTH is 256). Write attempts while full change neither the contents nor the count.
- R4: empty is 1 exactly when no word is held. Read attempts while empty leave rd_data and the count unchanged.
- R5: almost_empty is 1 when the held count is at or below the empty offset.
- R6: almost_full is 1 when the held count is at or above DEPTH minus the full offset.
- R7: Reset gives empty=1, almost_empty=1, full=0, almost_full=0 and rd_data=0, and sets both offsets to 7.
- R8: Each write-clock edge with ofs_load=1 stores ofs_data, clamped to DEPTH, into one offset. The first load after reset goes to the empty offset and the second to the full offset. The loads then keep alternating, starting again with the empty offset.
- R9: rd_data_oe equals out_en at all times.
- R10: With both clocks running unrelated and random enable patterns on both ports, every accepted word is read back once, in order, with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_clk | input | 1 | Write-side clock |
| wr_en_a | input | 1 | First write enable |
| wr_en_b | input | 1 | Second write enable |
| wr_data | input | 9 | Word to store |
| ofs_load | input | 1 | Offset load strobe (write domain) |
| ofs_data | input | 9 | Offset value to load |
| full | output | 1 | FIFO holds DEPTH words |
| almost_full | output | 1 | Count at or above DEPTH minus full offset |
| rd_clk | input | 1 | Read-side clock |
| rd_en_a | input | 1 | First read enable |
| rd_en_b | input | 1 | Second read enable |
| out_en | input | 1 | Output enable for the data bus |
| rd_data | output | 9 | Registered read word |
| rd_data_oe | output | 1 | Drive enable for rd_data |
| empty | output | 1 | FIFO holds no word |
| almost_empty | output | 1 | Count at or below empty offset |

## Verification
The in-line properties check four things on every edge of their own clock:
- a blocked write leaves the write pointer unchanged, and a blocked read leaves the read pointer and rd_data unchanged;
- full implies almost-full, and empty implies almost-empty;
- the read pointer advances by at most one per edge;
- the Gray write pointer flips no more than one bit per edge.

Some behaviour depends on counts, order and thresholds, and only the bench scenarios can show it:
- the exact count at which each flag changes, under the default and the reloaded offsets;
- the order in which offset loads land;
- word order under unrelated clocks with random single and dual enables.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int DCF_DATA_W  = 9;
  localparam int DCF_DEF_OFS = 7;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (rrst)    rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int DEPTH   = 256,
  parameter int DEF_OFS = 7,
  parameter int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [PW-1:0] rgray_s,
  input  logic          ofs_load,
  input  logic [PW-1:0] ofs_data,
  output logic          wr_ok,
  output logic [PW-2:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] ae_ofs,
  output logic          full,
  output logic          almost_full
);
  import dcf_pkg::*;

  localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
  localparam logic [PW-1:0] DEF_V   = PW'(DEF_OFS);

  logic [PW-1:0] wbin, wbin_nxt, rbin_s, cnt_nxt, ofs_in, af_ofs;
  logic          sel_full;

  assign wr_ok    = wr_req & ~full;
  assign wbin_nxt = wbin + PW'(wr_ok);
  assign rbin_s   = PW'(gray2bin(32'(rgray_s)));
  assign cnt_nxt  = wbin_nxt - rbin_s;
  assign ofs_in   = (ofs_data > DEPTH_V) ? DEPTH_V : ofs_data;
  assign waddr    = wbin[PW-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wbin        <= '0;
      wgray       <= '0;
      full        <= 1'b0;
      almost_full <= 1'b0;
      ae_ofs      <= DEF_V;
      af_ofs      <= DEF_V;
      sel_full    <= 1'b0;
    end else begin
      wbin        <= wbin_nxt;
      wgray       <= PW'(bin2gray(32'(wbin_nxt)));
      full        <= (cnt_nxt == DEPTH_V);
      almost_full <= (cnt_nxt >= (DEPTH_V - af_ofs));
      if (ofs_load) begin
        if (sel_full) af_ofs <= ofs_in;
        else          ae_ofs <= ofs_in;
        sel_full <= ~sel_full;
      end
    end
  end

  // R3: a write attempt while full must not move the pointer
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_req) |=> $stable(wbin));

  // R6: a full FIFO is always above the almost-full threshold
  p_full_af_r6: assert property (@(posedge clk) disable iff (rst)
    full |-> almost_full);

  // R10: the Gray pointer that crosses domains changes at most one bit
  p_gray_step_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot0(wgray ^ $past(wgray)));
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int DEPTH = 256,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] ae_ofs_s,
  output logic          rd_ok,
  output logic [PW-2:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty,
  output logic          almost_empty
);
  import dcf_pkg::*;

  logic [PW-1:0] rbin, rbin_nxt, wbin_s, cnt_nxt;

  assign rd_ok    = rd_req & ~empty;
  assign rbin_nxt = rbin + PW'(rd_ok);
  assign wbin_s   = PW'(gray2bin(32'(wgray_s)));
  assign cnt_nxt  = wbin_s - rbin_nxt;
  assign raddr    = rbin[PW-2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rbin         <= '0;
      rgray        <= '0;
      empty        <= 1'b1;
      almost_empty <= 1'b1;
    end else begin
      rbin         <= rbin_nxt;
      rgray        <= PW'(bin2gray(32'(rbin_nxt)));
      empty        <= (cnt_nxt == '0);
      almost_empty <= (cnt_nxt <= ae_ofs_s);
    end
  end

  // R4: a read attempt while empty must not move the pointer
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_req) |=> $stable(rbin));

  // R5: an empty FIFO is always below the almost-empty threshold
  p_empty_ae_r5: assert property (@(posedge clk) disable iff (rst)
    empty |-> almost_empty);

  // R2: the read pointer advances by one word at most per edge
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rbin == $past(rbin) || rbin == $past(rbin) + PW'(1)));
endmodule

// File: rtl/dual_clk_fifo_pf.sv
module dual_clk_fifo_pf #(
  parameter int DEPTH   = 256,
  parameter int DW      = dcf_pkg::DCF_DATA_W,
  parameter int DEF_OFS = dcf_pkg::DCF_DEF_OFS
) (
  input  logic                    rst,
  input  logic                    wr_clk,
  input  logic                    wr_en_a,
  input  logic                    wr_en_b,
  input  logic [DW-1:0]           wr_data,
  input  logic                    ofs_load,
  input  logic [$clog2(DEPTH):0]  ofs_data,
  output logic                    full,
  output logic                    almost_full,
  input  logic                    rd_clk,
  input  logic                    rd_en_a,
  input  logic                    rd_en_b,
  input  logic                    out_en,
  output logic [DW-1:0]           rd_data,
  output logic                    rd_data_oe,
  output logic                    empty,
  output logic                    almost_empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          wr_ok, rd_ok;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s, ae_ofs, ae_ofs_s;

  dcf_wr_ctrl #(.DEPTH(DEPTH), .DEF_OFS(DEF_OFS), .PW(PW)) u_wr (
    .clk(wr_clk), .rst(rst), .wr_req(wr_en_a & wr_en_b), .rgray_s(rgray_s),
    .ofs_load(ofs_load), .ofs_data(ofs_data), .wr_ok(wr_ok), .waddr(waddr),
    .wgray(wgray), .ae_ofs(ae_ofs), .full(full), .almost_full(almost_full)
  );

  dcf_rd_ctrl #(.DEPTH(DEPTH), .PW(PW)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_req(rd_en_a & rd_en_b), .wgray_s(wgray_s),
    .ae_ofs_s(ae_ofs_s), .rd_ok(rd_ok), .raddr(raddr), .rgray(rgray),
    .empty(empty), .almost_empty(almost_empty)
  );

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));
  dcf_sync2 #(.W(PW), .RST_VAL(PW'(DEF_OFS))) u_ofs (
    .clk(rd_clk), .rst(rst), .d(ae_ofs), .q(ae_ofs_s));

  dcf_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(wr_ok), .waddr(waddr), .wdata(wr_data),
    .rclk(rd_clk), .rrst(rst), .re(rd_ok), .raddr(raddr), .rdata(rd_data)
  );

  assign rd_data_oe = out_en;

  // R4: the output word holds on any edge that accepts no read
  p_data_hold_r4: assert property (@(posedge rd_clk) disable iff (rst)
    !rd_ok |=> $stable(rd_data));
endmodule

// File: tb/tb_dual_clk_fifo_pf.sv
module tb_dual_clk_fifo_pf;
  localparam int DEPTH = 256;

  logic rst = 1'b1, wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_en_a = 0, wr_en_b = 0, ofs_load = 0, rd_en_a = 0, rd_en_b = 0, out_en = 0;
  logic [8:0] wr_data = '0, ofs_data = '0;
  logic [8:0] rd_data;
  logic full, almost_full, rd_data_oe, empty, almost_empty;

  int checks = 0, errors = 0;
  bit done = 0, pend = 0;
  logic [8:0] expv, wdat = 9'd1, last;
  logic [8:0] q[$];

  always #5 wr_clk = ~wr_clk;
  always #7 rd_clk = ~rd_clk;

  dual_clk_fifo_pf dut (
    .rst(rst), .wr_clk(wr_clk), .wr_en_a(wr_en_a), .wr_en_b(wr_en_b), .wr_data(wr_data),
    .ofs_load(ofs_load), .ofs_data(ofs_data), .full(full), .almost_full(almost_full),
    .rd_clk(rd_clk), .rd_en_a(rd_en_a), .rd_en_b(rd_en_b), .out_en(out_en),
    .rd_data(rd_data), .rd_data_oe(rd_data_oe), .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int af_exp(input int cnt, input int ofs);
    return (cnt >= DEPTH - ofs) ? 1 : 0;
  endfunction

  function automatic int ae_exp(input int cnt, input int ofs);
    return (cnt <= ofs) ? 1 : 0;
  endfunction

  task automatic settle();
    repeat (12) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic load_ofs(input int v);
    @(negedge wr_clk);
    ofs_load = 1'b1;
    ofs_data = 9'(v);
    @(negedge wr_clk);
    ofs_load = 1'b0;
  endtask

  task automatic fill(input int n, input int afo);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      chk("R6 almost_full level", almost_full, af_exp(q.size(), afo));
      chk("R3 full level", full, (q.size() == DEPTH) ? 1 : 0);
      wr_en_a = 1'b1;
      wr_en_b = 1'b1;
      wr_data = wdat;
      if (!full) begin
        q.push_back(wdat);
        wdat = wdat + 9'd1;
      end
    end
    @(negedge wr_clk);
    wr_en_a = 1'b0;
    wr_en_b = 1'b0;
    chk("R3 count at full", q.size(), DEPTH);
  endtask

  task automatic drain(input int aeo);
    for (int i = 0; i < DEPTH + 4; i++) begin
      @(negedge rd_clk);
      if (pend) chk("R2 read order", rd_data, expv);
      pend = 0;
      chk("R4 empty level", empty, (q.size() == 0) ? 1 : 0);
      chk("R5 almost_empty level", almost_empty, ae_exp(q.size(), aeo));
      rd_en_a = 1'b1;
      rd_en_b = 1'b1;
      if (!empty) begin
        expv = q.pop_front();
        pend = 1;
      end
    end
    @(negedge rd_clk);
    rd_en_a = 1'b0;
    rd_en_b = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge rd_clk);
    rst = 1'b0;
    @(negedge rd_clk);
    // R7: flags and data after reset
    chk("R7 empty", empty, 1);
    chk("R7 almost_empty", almost_empty, 1);
    chk("R7 full", full, 0);
    chk("R7 almost_full", almost_full, 0);
    chk("R7 rd_data", rd_data, 0);
    chk("R9 oe low", rd_data_oe, 0);
    out_en = 1'b1;
    #1 chk("R9 oe high", rd_data_oe, 1);

    // R1: single write enables store nothing
    @(negedge wr_clk);
    wr_data = 9'h155;
    wr_en_a = 1'b1;
    repeat (5) @(negedge wr_clk);
    wr_en_a = 1'b0;
    wr_en_b = 1'b1;
    repeat (5) @(negedge wr_clk);
    wr_en_b = 1'b0;
    settle();
    chk("R1 single enable write", empty, 1);
    chk("R1 single enable full side", almost_full, 0);

    // R7 default offsets of 7 checked by the first fill and drain
    fill(DEPTH + 4, 7);
    settle();
    drain(7);
    // R4: reads while empty keep rd_data
    last = rd_data;
    rd_en_a = 1'b1;
    rd_en_b = 1'b1;
    repeat (5) @(negedge rd_clk);
    rd_en_a = 1'b0;
    rd_en_b = 1'b0;
    chk("R4 data hold on empty read", rd_data, last);
    chk("R4 still empty", empty, 1);

    // R8: first load empty offset, second full offset, third empty again
    load_ofs(3);
    load_ofs(20);
    load_ofs(5);
    settle();
    fill(DEPTH + 2, 20);
    settle();
    drain(5);

    // R10: random traffic on unrelated clocks
    settle();
    fork
      begin
        repeat (3000) begin
          @(negedge wr_clk);
          wr_en_a = ($urandom % 4) != 0;
          wr_en_b = ($urandom % 4) != 0;
          wr_data = wdat;
          if (wr_en_a && wr_en_b && !full) begin
            q.push_back(wdat);
            wdat = wdat + 9'd1;
          end
        end
        @(negedge wr_clk);
        wr_en_a = 1'b0;
        wr_en_b = 1'b0;
      end
      begin
        repeat (2200) begin
          @(negedge rd_clk);
          if (pend) chk("R10 random order", rd_data, expv);
          pend = 0;
          rd_en_a = ($urandom % 3) != 0;
          rd_en_b = ($urandom % 3) != 0;
          if (rd_en_a && rd_en_b && !empty) begin
            expv = q.pop_front();
            pend = 1;
          end
        end
        @(negedge rd_clk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
      end
    join
    settle();
    drain(5);
    chk("R10 all words drained", q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule